// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Signed-Overflow Trap

This block is the integer execution unit of a load-store RISC pipeline. In each cycle it accepts two 32-bit register operands, a 16-bit immediate field, a 5-bit shift-amount field and a 4-bit operation code. From these it produces a 32-bit result one clock later. A small front stage can replace operand B with the extended immediate. The extension is zero-fill for the bitwise operations and sign-fill for the arithmetic and compare operations.

The unit covers signed and unsigned add and subtract, the four bitwise operations (AND, OR, XOR, NOR), signed and unsigned set-less-than, and left-logical, right-logical and right-arithmetic shifts. A shift takes its amount either from the constant field or from the low bits of operand B. Only the signed add and signed subtract codes can raise the overflow trap. The add-immediate form is the signed add code with the immediate selected. When the trap fires, the write-enable output is held low so that the destination register is not written. The exception handler, the register file and multiply/divide sit outside this block.

Outputs are registered, with one cycle of latency, and synchronous active-high reset clears them.

Top module: `int_alu_core`

## Requirements
- R1: For op_sel 0 (signed add) and op_sel 2 (signed subtract), result is a+B or a-B modulo 2^32. ovf_trap goes high exactly when the operation overflows in two's complement. With use_imm=1, op_sel 0 acts as add-immediate.
- R2: op_sel 1 (unsigned add) and op_sel 3 (unsigned subtract) return the same wrapped sum or difference, and ovf_trap stays low.
- R3: op_sel 4, 5, 6 and 7 return a&B, a|B, a^B and ~(a|B) respectively, and ovf_trap stays low.
- R4: op_sel 8 returns 1 when a<B as signed 32-bit numbers, and 0 otherwise. op_sel 9 makes the same comparison with both values treated as unsigned. Bits 31:1 of the result are zero.
- R5: op_sel 10 shifts operand a left with zero fill. op_sel 11 shifts it right with zero fill. op_sel 12 shifts it right and fills with bit 31 of a. No shift raises ovf_trap.
- R6: With shift_by_reg=0 the shift amount is shamt. With shift_by_reg=1 it is B[4:0]; shamt and B[31:5] then have no effect.
- R7: With use_imm=1, B is replaced by imm extended to 32 bits. The extension is zero-fill for op_sel 4 to 7 and fill with imm[15] for every other code. With use_imm=0, B is operand b.
- R8: wr_en is high exactly when out_valid is high and ovf_trap is low. A trapped operation never enables the write.
- R9: out_valid, result, ovf_trap and wr_en reflect the inputs sampled at the previous rising edge. While rst is high at a rising edge, all outputs are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 4 | Operation code (0 to 12) |
| a | input | 32 | Operand A; also the value that is shifted |
| b | input | 32 | Operand B register value |
| imm | input | 16 | Immediate field |
| use_imm | input | 1 | Replace B with the extended immediate |
| shamt | input | 5 | Constant shift amount |
| shift_by_reg | input | 1 | Take the shift amount from B[4:0] |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Operation result |
| ovf_trap | output | 1 | Signed overflow exception |
| wr_en | output | 1 | Destination write enable |

## Verification
Several properties are checked on every cycle. The write enable must never coexist with a trap, and must follow a valid, untrapped result. A valid input must be followed by a valid output. The unsigned, bitwise, compare and shift codes must never trap. A signed add of operands with opposite signs must never trap. A set-less-than result must have zero upper bits. The exact arithmetic values, the overflow boundary points, the choice between zero and sign extension, the shift fill, and the independence from the upper bits of the shift register are shown only by the bench's directed corners and its seeded random operations compared against its own model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDU = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBU = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_SLT  = 4'd8,
    OP_SLTU = 4'd9,
    OP_SLL  = 4'd10,
    OP_SRL  = 4'd11,
    OP_SRA  = 4'd12
  } alu_op_e;

  function automatic logic op_is_bitwise(alu_op_e o);
    return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR) || (o == OP_NOR);
  endfunction

  function automatic logic op_is_subtract(alu_op_e o);
    return (o == OP_SUB) || (o == OP_SUBU) || (o == OP_SLT) || (o == OP_SLTU);
  endfunction

  function automatic logic op_can_trap(alu_op_e o);
    return (o == OP_ADD) || (o == OP_SUB);
  endfunction

endpackage

// File: rtl/alu_operand_prep.sv
module alu_operand_prep
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int SH_W  = 5
) (
  input  alu_op_e          op,
  input  logic [W-1:0]     b_reg,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic [SH_W-1:0]  shamt,
  input  logic             shift_by_reg,
  output logic [W-1:0]     b_eff,
  output logic [SH_W-1:0]  sh_amt
);

  localparam int PAD_W = W - IMM_W;

  logic [W-1:0] imm_zext;
  logic [W-1:0] imm_sext;

  assign imm_zext = {{PAD_W{1'b0}}, imm};
  assign imm_sext = {{PAD_W{imm[IMM_W-1]}}, imm};

  always_comb begin
    if (!use_imm)
      b_eff = b_reg;
    else if (op_is_bitwise(op))
      b_eff = imm_zext;
    else
      b_eff = imm_sext;
  end

  assign sh_amt = shift_by_reg ? b_eff[SH_W-1:0] : shamt;

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
  import alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         ovf_raw,
  output logic         lt_signed,
  output logic         lt_unsigned
);

  logic         do_sub;
  logic [W-1:0] b_op;
  logic         carry;

  assign do_sub = op_is_subtract(op);
  assign b_op   = do_sub ? ~b : b;
  assign {carry, sum} = {1'b0, a} + {1'b0, b_op} + {{W{1'b0}}, do_sub};

  // operands of equal sign (after inversion) yielding a different sign
  assign ovf_raw     = (a[W-1] == b_op[W-1]) && (sum[W-1] != a[W-1]);
  assign lt_signed   = sum[W-1] ^ ovf_raw;
  assign lt_unsigned = ~carry;

endmodule

// File: rtl/alu_bitshift.sv
module alu_bitshift
  import alu_pkg::*;
#(
  parameter int W    = 32,
  parameter int SH_W = 5
) (
  input  alu_op_e         op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [SH_W-1:0] sh,
  output logic [W-1:0]    logic_y,
  output logic [W-1:0]    shift_y
);

  logic         go_left;
  logic         fill;
  logic [W-1:0] a_rev;
  logic [W-1:0] src;
  logic [W-1:0] stage [SH_W+1];
  logic [W-1:0] out_rev;

  assign go_left = (op == OP_SLL);
  assign fill    = (op == OP_SRA) & a[W-1];

  always_comb begin
    case (op)
      OP_AND:  logic_y = a & b;
      OP_OR:   logic_y = a | b;
      OP_XOR:  logic_y = a ^ b;
      OP_NOR:  logic_y = ~(a | b);
      default: logic_y = '0;
    endcase
  end

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_rev
      assign a_rev[i]   = a[W-1-i];
      assign out_rev[i] = stage[SH_W][W-1-i];
    end
  endgenerate

  assign src      = go_left ? a_rev : a;
  assign stage[0] = src;

  // logarithmic right shifter; left shifts run through it bit-reversed
  genvar k;
  generate
    for (k = 0; k < SH_W; k++) begin : g_stage
      localparam int STEP = 1 << k;
      assign stage[k+1] = sh[k] ? {{STEP{fill}}, stage[k][W-1:STEP]} : stage[k];
    end
  endgenerate

  assign shift_y = go_left ? out_rev : stage[SH_W];

endmodule

// File: rtl/int_alu_core.sv
module int_alu_core
  import alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int SH_W  = 5,
  parameter int OP_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  op_sel,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic [SH_W-1:0]  shamt,
  input  logic             shift_by_reg,
  output logic             out_valid,
  output logic [W-1:0]     result,
  output logic             ovf_trap,
  output logic             wr_en
);

  alu_op_e         op;
  logic [W-1:0]    b_eff;
  logic [SH_W-1:0] sh_amt;
  logic [W-1:0]    sum;
  logic            ovf_raw;
  logic            lt_s;
  logic            lt_u;
  logic [W-1:0]    logic_y;
  logic [W-1:0]    shift_y;
  logic [W-1:0]    nxt_result;
  logic            nxt_trap;

  assign op = alu_op_e'(op_sel);

  alu_operand_prep #(.W(W), .IMM_W(IMM_W), .SH_W(SH_W)) u_prep (
    .op           (op),
    .b_reg        (b),
    .imm          (imm),
    .use_imm      (use_imm),
    .shamt        (shamt),
    .shift_by_reg (shift_by_reg),
    .b_eff        (b_eff),
    .sh_amt       (sh_amt)
  );

  alu_addsub #(.W(W)) u_addsub (
    .op          (op),
    .a           (a),
    .b           (b_eff),
    .sum         (sum),
    .ovf_raw     (ovf_raw),
    .lt_signed   (lt_s),
    .lt_unsigned (lt_u)
  );

  alu_bitshift #(.W(W), .SH_W(SH_W)) u_bitshift (
    .op      (op),
    .a       (a),
    .b       (b_eff),
    .sh      (sh_amt),
    .logic_y (logic_y),
    .shift_y (shift_y)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: nxt_result = sum;
      OP_AND, OP_OR, OP_XOR, OP_NOR:    nxt_result = logic_y;
      OP_SLT:                           nxt_result = {{(W-1){1'b0}}, lt_s};
      OP_SLTU:                          nxt_result = {{(W-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA:           nxt_result = shift_y;
      default:                          nxt_result = '0;
    endcase
  end

  assign nxt_trap = op_can_trap(op) & ovf_raw;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf_trap  <= 1'b0;
      wr_en     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      result    <= nxt_result;
      ovf_trap  <= in_valid & nxt_trap;
      wr_en     <= in_valid & ~nxt_trap;
    end
  end

endmodule

// File: rtl/int_alu_core_chk.sv
module int_alu_core_chk #(
  parameter int W     = 32,
  parameter int IMM_W = 16,
  parameter int SH_W  = 5,
  parameter int OP_W  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [OP_W-1:0]  op_sel,
  input logic [W-1:0]     a,
  input logic [W-1:0]     b,
  input logic             use_imm,
  input logic             out_valid,
  input logic [W-1:0]     result,
  input logic             ovf_trap,
  input logic             wr_en
);

  // R8
  wr_blocks_trap_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (!ovf_trap && out_valid));

  // R8
  wr_follows_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !ovf_trap) |-> wr_en);

  // R9
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel != 4'd0 && op_sel != 4'd2) |=> !ovf_trap);

  // R1
  mixed_sign_add_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 4'd0 && !use_imm && (a[W-1] != b[W-1])) |=> !ovf_trap);

  // R4
  slt_width_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op_sel == 4'd8 || op_sel == 4'd9)) |=> (result[W-1:1] == '0));

endmodule

bind int_alu_core int_alu_core_chk #(.W(W), .IMM_W(IMM_W), .SH_W(SH_W), .OP_W(OP_W)) u_chk (.*);

// File: tb/test_int_alu_core.sv
module test_int_alu_core;
  import alu_pkg::*;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  op_sel;
  logic [31:0] a, b;
  logic [15:0] imm;
  logic        use_imm;
  logic [4:0]  shamt;
  logic        shift_by_reg;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf_trap;
  logic        wr_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  int_alu_core i_int_alu_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .a(a), .b(b), .imm(imm), .use_imm(use_imm), .shamt(shamt),
    .shift_by_reg(shift_by_reg), .out_valid(out_valid), .result(result),
    .ovf_trap(ovf_trap), .wr_en(wr_en)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string tag_of(input int o, input logic ui, input logic byreg);
    if (o == 0 || o == 2) return ui ? "R1/R7" : "R1";
    if (o == 1 || o == 3) return ui ? "R2/R7" : "R2";
    if (o >= 4 && o <= 7) return ui ? "R3/R7" : "R3";
    if (o == 8 || o == 9) return ui ? "R4/R7" : "R4";
    return byreg ? "R5/R6" : "R5";
  endfunction

  task automatic model(input int o, input logic [31:0] av, input logic [31:0] bv,
                       input logic [15:0] iv, input logic ui, input logic [4:0] sv,
                       input logic byreg, output logic [31:0] r, output logic ov);
    logic [31:0] bb;
    logic [4:0]  s;
    if (!ui) bb = bv;
    else if (o >= 4 && o <= 7) bb = {16'h0000, iv};
    else bb = {{16{iv[15]}}, iv};
    s  = byreg ? bb[4:0] : sv;
    ov = 1'b0;
    case (o)
      0: begin r = av + bb; ov = (av[31] == bb[31]) && (r[31] != av[31]); end
      1: r = av + bb;
      2: begin r = av - bb; ov = (av[31] != bb[31]) && (r[31] != av[31]); end
      3: r = av - bb;
      4: r = av & bb;
      5: r = av | bb;
      6: r = av ^ bb;
      7: r = ~(av | bb);
      8: r = ($signed(av) < $signed(bb)) ? 32'd1 : 32'd0;
      9: r = (av < bb) ? 32'd1 : 32'd0;
      10: r = av << s;
      11: r = av >> s;
      default: r = $unsigned($signed(av) >>> s);
    endcase
  endtask

  task automatic run_op(input int o, input logic [31:0] av, input logic [31:0] bv,
                        input logic [15:0] iv, input logic ui, input logic [4:0] sv,
                        input logic byreg);
    logic [31:0] er;
    logic        eo;
    string       t;
    model(o, av, bv, iv, ui, sv, byreg, er, eo);
    t = tag_of(o, ui, byreg);
    in_valid = 1'b1; op_sel = 4'(o); a = av; b = bv; imm = iv;
    use_imm = ui; shamt = sv; shift_by_reg = byreg;
    @(negedge clk);
    chk({t, " result"}, result, er);
    chk({t, " ovf_trap"}, {31'd0, ovf_trap}, {31'd0, eo});
    chk("R8 wr_en", {31'd0, wr_en}, {31'd0, ~eo});
    chk("R9 out_valid", {31'd0, out_valid}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; in_valid = 1'b0; op_sel = '0; a = '0; b = '0; imm = '0;
    use_imm = 1'b0; shamt = '0; shift_by_reg = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk("R9 reset result", result, 32'd0);
    chk("R9 reset wr_en", {31'd0, wr_en}, 32'd0);
    rst = 1'b0;

    // R1 overflow corners
    run_op(0, 32'h7fffffff, 32'h00000001, 16'h0, 0, 5'd0, 0);
    run_op(0, 32'h80000000, 32'hffffffff, 16'h0, 0, 5'd0, 0);
    run_op(0, 32'h7fffffff, 32'hffffffff, 16'h0, 0, 5'd0, 0);
    run_op(2, 32'h80000000, 32'h00000001, 16'h0, 0, 5'd0, 0);
    run_op(2, 32'h7fffffff, 32'hffffffff, 16'h0, 0, 5'd0, 0);
    run_op(2, 32'h00000000, 32'h80000000, 16'h0, 0, 5'd0, 0);
    run_op(0, 32'h7fffffff, 32'h0, 16'h0001, 1, 5'd0, 0);
    run_op(0, 32'h80000000, 32'h0, 16'h8000, 1, 5'd0, 0);
    // R2 unsigned never traps
    run_op(1, 32'h7fffffff, 32'h00000001, 16'h0, 0, 5'd0, 0);
    run_op(3, 32'h80000000, 32'h00000001, 16'h0, 0, 5'd0, 0);
    // R7 extension
    run_op(1, 32'h0, 32'h0, 16'h8000, 1, 5'd0, 0);
    run_op(5, 32'h0, 32'h0, 16'h8000, 1, 5'd0, 0);
    run_op(7, 32'h0f0f0000, 32'h0, 16'hf0f0, 1, 5'd0, 0);
    // R4 compare corners
    run_op(8, 32'hffffffff, 32'h00000001, 16'h0, 0, 5'd0, 0);
    run_op(9, 32'hffffffff, 32'h00000001, 16'h0, 0, 5'd0, 0);
    run_op(8, 32'h80000000, 32'h7fffffff, 16'h0, 0, 5'd0, 0);
    run_op(8, 32'h5, 32'h5, 16'h0, 0, 5'd0, 0);
    run_op(9, 32'h0, 32'h0, 16'hffff, 1, 5'd0, 0);
    // R5 shift fill, R6 amount source
    run_op(12, 32'h80000000, 32'h0, 16'h0, 0, 5'd4, 0);
    run_op(11, 32'h80000000, 32'h0, 16'h0, 0, 5'd4, 0);
    run_op(10, 32'h80000001, 32'h0, 16'h0, 0, 5'd31, 0);
    run_op(12, 32'h80000000, 32'h00000021, 16'h0, 0, 5'd9, 1);
    run_op(10, 32'h00000003, 32'hffffffe0, 16'h0, 0, 5'd7, 1);

    // idle cycle: R9
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 idle out_valid", {31'd0, out_valid}, 32'd0);
    chk("R8 idle wr_en", {31'd0, wr_en}, 32'd0);

    for (int n = 0; n < 600; n++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (n % 4 == 0) ra = {ra[31], 31'h7ffffff0 ^ ra[30:0] & 31'hf};
      run_op(int'($urandom % 13), ra, rb, 16'($urandom), 1'($urandom),
             5'($urandom), 1'($urandom));
    end

    in_valid = 1'b0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule